// File: doc/BRIEF.md
# Command-FIFO Driven I2C Master

This block is an I2C bus master whose every bus action is requested by a byte written into an eight-entry command queue. An opcode can ask for a START, a STOP, a single 0 bit, a single 1 bit, an eight-bit write, an eight-bit read, or a check of the acknowledge bit. The eight-bit write opcode takes the next queue byte as its payload. A read places its byte into a four-entry read-data queue. Software builds a transfer by writing opcodes and payloads in order. After each received byte it sends a 0 bit (ACK) or a 1 bit (NACK).

Each bus bit lasts four quarter periods. Each quarter is `div_val + 2` clocks long. For a given peripheral clock and a target bus rate, the divisor is `((f_clk / rate) >> 2) - 2`. Sticky status bits report a push into a full command queue, a pop from an empty read queue, and bus errors. A bus error is a NACK seen by the acknowledge check, or an opcode that is not recognised. A separate input clears the sticky bits.

The SCL and SDA outputs give the level the master wants on each line, where 1 means released. The pad drivers, arbitration and clock stretching are handled elsewhere.

Top module: `i2c_cmd_master`

## Requirements
- R1: After reset, scl_o and sda_o are 1, cmd_empty is 1, rd_ready is 0, and all three sticky status bits are 0.
- R2: Every bus bit lasts 4*(div_val+2) clocks. SCL is low for the first two quarters and high for the last two. With div_val = ((f_clk/rate)>>2)-2, two SCL rising edges inside one byte are f_clk/rate clocks apart.
- R3: Opcode 0x10 sends one 0 bit and opcode 0x11 sends one 1 bit. On SDA is set in the second quarter. For every opcode other than START and STOP, SDA does not change while SCL is high.
- R4: Opcode 0x12 takes the next queue byte as payload and sends it MSB first. The payload is never decoded as an opcode, even when it is 0x13. If the payload has not been pushed yet, the engine waits for it with the lines unchanged.
- R5: Opcode 0x13 releases SDA for eight bits and samples SDA, MSB first, in the last clock of each bit's third quarter. It then pushes the byte into the read queue. rd_ready is 1 while that queue holds data, and rd_data shows the oldest entry. A 0x13 opcode stays in the command queue while the read queue is full.
- R6: Opcode 0x14 releases SDA for one bit. If the sampled level is 1, st_bus_err is set.
- R7: Opcode 0x01 makes a START, with SDA going 1 to 0 while SCL is high. Opcode 0x02 makes a STOP, with SDA going 0 to 1 while SCL is high.
- R8: The command queue holds 8 bytes. A push while it is full drops the byte and sets st_cmd_ofl. cmd_empty is 1 exactly when the queue holds no byte.
- R9: rd_pop while the read queue is empty sets st_rd_ufl and leaves the queue unchanged.
- R10: An opcode outside the set above is removed from the queue, sets st_bus_err, and causes no bus activity.
- R11: clr_status clears the sticky status bits. A set condition in the same cycle wins over the clear.
- R12: Between opcodes, SCL stays high and SDA keeps the level from the end of the last bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_val | input | DIV_W | Quarter-period divisor (quarter = div_val+2 clocks) |
| cmd_wr | input | 1 | Push cmd_data into the command queue |
| cmd_data | input | 8 | Opcode or payload byte |
| cmd_empty | output | 1 | Command queue is empty |
| rd_pop | input | 1 | Remove the oldest read byte |
| rd_data | output | 8 | Oldest read byte |
| rd_ready | output | 1 | Read queue holds data |
| clr_status | input | 1 | Clear sticky status bits |
| st_cmd_ofl | output | 1 | Sticky: push into a full command queue |
| st_rd_ufl | output | 1 | Sticky: pop from an empty read queue |
| st_bus_err | output | 1 | Sticky: NACK seen or unknown opcode |
| scl_o | output | 1 | SCL level requested (1 = released) |
| sda_o | output | 1 | SDA level requested (1 = released) |
| sda_i | input | 1 | SDA level seen on the bus |

## Verification
The hardest state to reach from the ports is a read opcode held back because the read queue is full. The bench reaches it by queueing five reads while the slave model keeps SDA released, then popping only afterwards. A second hard case is a payload byte of 0x13 that must not be decoded as a read. It is reached by a write opcode followed by that payload, inside a full START to STOP transfer. A bus monitor records every SCL rising edge, and a reference model predicts both lines on every clock. Overflow is reached by pushing eleven bytes back to back while the engine is busy with its first bit.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam logic [7:0] OP_START = 8'h01;
  localparam logic [7:0] OP_STOP  = 8'h02;
  localparam logic [7:0] OP_W0    = 8'h10;
  localparam logic [7:0] OP_W1    = 8'h11;
  localparam logic [7:0] OP_W8    = 8'h12;
  localparam logic [7:0] OP_RD8   = 8'h13;
  localparam logic [7:0] OP_VFY   = 8'h14;

  typedef enum logic [2:0] {K_START, K_STOP, K_W0, K_W1, K_W8, K_RD8, K_VFY} kind_t;
  typedef enum logic [1:0] {E_IDLE, E_PAY, E_RUN} est_t;

  // SDA level requested in quarters 1..3 of a bus bit
  function automatic logic phase_sda(input kind_t k, input logic dbit, input logic [1:0] ph);
    case (k)
      K_START: return (ph != 2'd3);
      K_STOP:  return (ph == 2'd3);
      default: return dbit;
    endcase
  endfunction
endpackage

// File: rtl/i2cm_fifo.sv
module i2cm_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign full    = (cnt == FULLC);
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
  import i2cm_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_val,
  input  logic             cq_empty,
  input  logic [7:0]       cq_head,
  output logic             cq_pop,
  input  logic             rq_full,
  output logic             rq_push,
  output logic [7:0]       rq_din,
  input  logic             sda_i,
  output logic             scl_o,
  output logic             sda_o,
  output logic             op_bad,
  output logic             nack_seen
);
  localparam int QW = DIV_W + 1;

  function automatic logic [QW-1:0] quarter_last(input logic [DIV_W-1:0] d);
    return {1'b0, d} + QW'(1);   // quarter length d+2, last index d+1
  endfunction

  est_t        st;
  kind_t       kind, dec_kind;
  logic        dec_ok;
  logic [QW-1:0] qcnt;
  logic [1:0]  phase;
  logic [2:0]  bitn;
  logic [7:0]  sh, rx;
  logic        samp, sclq, sdaq;
  logic        running, q_last, smp_now, bit_end, lastb, dbit, ctrl_run;

  always_comb begin
    dec_ok   = 1'b1;
    dec_kind = K_W1;
    case (cq_head)
      OP_START: dec_kind = K_START;
      OP_STOP:  dec_kind = K_STOP;
      OP_W0:    dec_kind = K_W0;
      OP_W1:    dec_kind = K_W1;
      OP_W8:    dec_kind = K_W8;
      OP_RD8:   dec_kind = K_RD8;
      OP_VFY:   dec_kind = K_VFY;
      default:  dec_ok   = 1'b0;
    endcase
  end

  assign running  = (st == E_RUN);
  assign ctrl_run = running && (kind == K_START || kind == K_STOP);
  assign q_last   = (qcnt == quarter_last(div_val));
  assign smp_now  = running && (phase == 2'd2) && q_last;
  assign bit_end  = running && (phase == 2'd3) && q_last;
  assign lastb    = (kind == K_W8 || kind == K_RD8) ? (bitn == 3'd7) : 1'b1;
  assign dbit     = (kind == K_W0) ? 1'b0 : (kind == K_W8) ? sh[7] : 1'b1;

  assign cq_pop    = !cq_empty && ((st == E_PAY) ||
                     ((st == E_IDLE) && !(cq_head == OP_RD8 && rq_full)));
  assign op_bad    = (st == E_IDLE) && cq_pop && !dec_ok;
  assign nack_seen = bit_end && (kind == K_VFY) && samp;
  assign rq_push   = bit_end && lastb && (kind == K_RD8);
  assign rq_din    = rx;

  assign scl_o = running ? phase[1] : sclq;
  assign sda_o = running ? ((phase == 2'd0) ? sdaq : phase_sda(kind, dbit, phase)) : sdaq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= E_IDLE; kind <= K_W1; qcnt <= '0; phase <= '0; bitn <= '0;
      sh <= '0; rx <= '0; samp <= 1'b1; sclq <= 1'b1; sdaq <= 1'b1;
    end else begin
      case (st)
        E_IDLE: if (cq_pop && dec_ok) begin
          if (dec_kind == K_W8) st <= E_PAY;
          else begin st <= E_RUN; kind <= dec_kind; end
          qcnt <= '0; phase <= '0; bitn <= '0;
        end
        E_PAY: if (cq_pop) begin
          sh <= cq_head; kind <= K_W8; st <= E_RUN;
        end
        default: begin
          if (q_last) begin qcnt <= '0; phase <= phase + 2'd1; end
          else qcnt <= qcnt + 1'b1;
          if (smp_now) begin samp <= sda_i; rx <= {rx[6:0], sda_i}; end
          if (bit_end) begin
            sclq <= 1'b1;
            sdaq <= phase_sda(kind, dbit, 2'd3);
            sh   <= {sh[6:0], 1'b0};
            bitn <= bitn + 3'd1;
            if (lastb) st <= E_IDLE;
          end
        end
      endcase
    end
  end

  // R3
  sda_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_o && $past(scl_o) && !ctrl_run && !$past(ctrl_run)) |-> (sda_o == $past(sda_o)));
  // R5
  rd_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rq_push |-> !rq_full);
  // R4
  payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == E_PAY && cq_pop) |=> (running && kind == K_W8));
endmodule

// File: rtl/i2c_cmd_master.sv
module i2c_cmd_master
  import i2cm_pkg::*;
#(
  parameter int CMD_DEPTH = 8,
  parameter int RD_DEPTH  = 4,
  parameter int DIV_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_val,
  input  logic             cmd_wr,
  input  logic [7:0]       cmd_data,
  output logic             cmd_empty,
  input  logic             rd_pop,
  output logic [7:0]       rd_data,
  output logic             rd_ready,
  input  logic             clr_status,
  output logic             st_cmd_ofl,
  output logic             st_rd_ufl,
  output logic             st_bus_err,
  output logic             scl_o,
  output logic             sda_o,
  input  logic             sda_i
);
  logic       cq_full, cq_pop;
  logic [7:0] cq_head;
  logic       rq_full, rq_empty, rq_push;
  logic [7:0] rq_din;
  logic       op_bad, nack_seen;

  i2cm_fifo #(.W(8), .DEPTH(CMD_DEPTH)) u_cmdq (
    .clk(clk), .rst_n(rst_n), .push(cmd_wr), .din(cmd_data), .pop(cq_pop),
    .dout(cq_head), .full(cq_full), .empty(cmd_empty));

  i2cm_fifo #(.W(8), .DEPTH(RD_DEPTH)) u_rdq (
    .clk(clk), .rst_n(rst_n), .push(rq_push), .din(rq_din), .pop(rd_pop),
    .dout(rd_data), .full(rq_full), .empty(rq_empty));

  i2cm_engine #(.DIV_W(DIV_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .div_val(div_val),
    .cq_empty(cmd_empty), .cq_head(cq_head), .cq_pop(cq_pop),
    .rq_full(rq_full), .rq_push(rq_push), .rq_din(rq_din),
    .sda_i(sda_i), .scl_o(scl_o), .sda_o(sda_o),
    .op_bad(op_bad), .nack_seen(nack_seen));

  assign rd_ready = !rq_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_cmd_ofl <= 1'b0;
      st_rd_ufl  <= 1'b0;
      st_bus_err <= 1'b0;
    end else begin
      st_cmd_ofl <= (st_cmd_ofl && !clr_status) || (cmd_wr && cq_full);
      st_rd_ufl  <= (st_rd_ufl  && !clr_status) || (rd_pop && rq_empty);
      st_bus_err <= (st_bus_err && !clr_status) || op_bad || nack_seen;
    end
  end

  // R8
  cmd_ofl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cq_full) |=> st_cmd_ofl);
  // R9
  rd_ufl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pop && rq_empty) |=> st_rd_ufl);
  // R10
  bad_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_bad |=> st_bus_err);
  // R11
  clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_status && !op_bad && !nack_seen) |=> !st_bus_err);
endmodule

// File: tb/i2c_cmd_master_bench.sv
module i2c_cmd_master_bench;
  localparam int CLK_PERIOD = 10;
  localparam int F_CLK = 8_000_000;
  localparam int RATE  = 400_000;

  function automatic int div_for(input int fclk, input int rate);
    return ((fclk / rate) >> 2) - 2;
  endfunction

  localparam int DIV = div_for(F_CLK, RATE);
  localparam int QL  = DIV + 2;

  logic clk = 0, rst_n = 0;
  logic cmd_wr = 0, rd_pop = 0, clr_status = 0;
  logic [7:0] cmd_data = 0;
  logic [7:0] div_val = 8'(DIV);
  logic cmd_empty, rd_ready, st_cmd_ofl, st_rd_ufl, st_bus_err, scl_o, sda_o, sda_i;
  logic [7:0] rd_data;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit finished = 0;

  // slave: 0 release, 1 hold low, 2 shift byte out on SCL falls
  int slv_mode = 0;
  logic [7:0] slv_byte = 8'hFF;
  logic slv_pull = 0;
  assign sda_i = sda_o & ~((slv_mode == 1) | ((slv_mode == 2) & slv_pull));
  always @(negedge scl_o) begin
    slv_pull <= ~slv_byte[7];
    slv_byte <= {slv_byte[6:0], 1'b1};
  end

  i2c_cmd_master u_i2c_cmd_master (
    .clk(clk), .rst_n(rst_n), .div_val(div_val), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
    .cmd_empty(cmd_empty), .rd_pop(rd_pop), .rd_data(rd_data), .rd_ready(rd_ready),
    .clr_status(clr_status), .st_cmd_ofl(st_cmd_ofl), .st_rd_ufl(st_rd_ufl),
    .st_bus_err(st_bus_err), .scl_o(scl_o), .sda_o(sda_o), .sda_i(sda_i));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  logic [7:0] mq[$];
  logic [7:0] mr[$];
  int m_st, m_kind, m_ph, m_qc, m_bit, m_nb;
  logic [7:0] m_sh, m_rx, m_op;
  logic m_samp, m_sclq, m_sdaq, m_ofl, m_ufl, m_err;
  int pre_c, pre_r;
  bit m_rpush, m_seterr, qlast;

  function automatic logic blvl(input int k, input logic [7:0] sh, input int ph);
    case (k)
      0: return ph != 3;
      1: return ph == 3;
      2: return 1'b0;
      4: return sh[7];
      default: return 1'b1;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mq.delete(); mr.delete();
      m_st = 0; m_kind = 3; m_ph = 0; m_qc = 0; m_bit = 0; m_nb = 1;
      m_sh = 0; m_rx = 0; m_samp = 1; m_sclq = 1; m_sdaq = 1;
      m_ofl = 0; m_ufl = 0; m_err = 0;
    end else begin
      pre_c = mq.size(); pre_r = mr.size();
      m_rpush = 0; m_seterr = 0;
      if (m_st == 0) begin
        if (pre_c > 0 && !(mq[0] == 8'h13 && pre_r == 4)) begin
          m_op = mq.pop_front();
          m_ph = 0; m_qc = 0; m_bit = 0; m_nb = 1; m_st = 2;
          case (m_op)
            8'h01: m_kind = 0;
            8'h02: m_kind = 1;
            8'h10: m_kind = 2;
            8'h11: m_kind = 3;
            8'h12: m_st = 1;
            8'h13: begin m_kind = 5; m_nb = 8; end
            8'h14: m_kind = 6;
            default: begin m_st = 0; m_seterr = 1; end
          endcase
        end
      end else if (m_st == 1) begin
        if (pre_c > 0) begin m_sh = mq.pop_front(); m_kind = 4; m_nb = 8; m_st = 2; end
      end else begin
        qlast = (m_qc == QL - 1);
        if (m_ph == 2 && qlast) begin m_samp = sda_i; m_rx = {m_rx[6:0], sda_i}; end
        if (m_ph == 3 && qlast) begin
          m_sclq = 1; m_sdaq = blvl(m_kind, m_sh, 3);
          m_sh = m_sh << 1; m_bit++;
          if (m_kind == 6 && m_samp) m_seterr = 1;
          if (m_bit == m_nb) begin m_st = 0; if (m_kind == 5) m_rpush = 1; end
        end
        if (qlast) begin m_qc = 0; m_ph = (m_ph + 1) % 4; end else m_qc++;
      end
      if (cmd_wr) begin if (pre_c == 8) m_ofl = 1; else mq.push_back(cmd_data); end
      if (rd_pop) begin if (pre_r == 0) m_ufl = 1; else void'(mr.pop_front()); end
      if (m_rpush) mr.push_back(m_rx);
      if (clr_status) begin m_ofl = m_ofl && (cmd_wr && pre_c == 8); m_ufl = m_ufl && (rd_pop && pre_r == 0); m_err = 0; end
      if (m_seterr) m_err = 1;
    end
  end

  logic e_scl, e_sda;
  always @(negedge clk) if (rst_n) begin
    e_scl = (m_st == 2) ? (m_ph >= 2) : m_sclq;
    e_sda = (m_st == 2) ? ((m_ph == 0) ? m_sdaq : blvl(m_kind, m_sh, m_ph)) : m_sdaq;
    chk(scl_o === e_scl, "R2 scl_o", 32'(scl_o), 32'(e_scl));
    chk(sda_o === e_sda, "R3 sda_o", 32'(sda_o), 32'(e_sda));
    chk(cmd_empty === (mq.size() == 0), "R8 cmd_empty", 32'(cmd_empty), 32'(mq.size() == 0));
    chk(rd_ready === (mr.size() != 0), "R5 rd_ready", 32'(rd_ready), 32'(mr.size() != 0));
    if (mr.size() != 0) chk(rd_data === mr[0], "R5 rd_data", 32'(rd_data), 32'(mr[0]));
    chk(st_cmd_ofl === m_ofl, "R8 st_cmd_ofl", 32'(st_cmd_ofl), 32'(m_ofl));
    chk(st_rd_ufl === m_ufl, "R9 st_rd_ufl", 32'(st_rd_ufl), 32'(m_ufl));
    chk(st_bus_err === m_err, "R6 st_bus_err", 32'(st_bus_err), 32'(m_err));
  end

  // ---------------- bus monitor ----------------
  logic mon_bits[$];
  int   mon_t[$];
  int   n_start = 0, n_stop = 0;
  always @(posedge scl_o) begin mon_bits.push_back(sda_o); mon_t.push_back(cyc); end
  always @(negedge sda_o) if (scl_o && rst_n) n_start++;
  always @(posedge sda_o) if (scl_o && rst_n) n_stop++;

  // ---------------- stimulus ----------------
  task automatic push(input logic [7:0] b);
    @(negedge clk); cmd_wr = 1; cmd_data = b;
    @(negedge clk); cmd_wr = 0;
  endtask
  task automatic pulse_pop;
    @(negedge clk); rd_pop = 1; @(negedge clk); rd_pop = 0;
  endtask
  task automatic pulse_clr;
    @(negedge clk); clr_status = 1; @(negedge clk); clr_status = 0;
  endtask
  task automatic settle;
    while (!cmd_empty) @(negedge clk);
    repeat (8 * 4 * QL + 20) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic exp_bits[$];
    int s0, p0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(scl_o && sda_o, "R1 lines idle high", {scl_o, sda_o}, 2'b11);
    chk(cmd_empty && !rd_ready, "R1 queues empty", {cmd_empty, rd_ready}, 2'b10);
    chk(!st_cmd_ofl && !st_rd_ufl && !st_bus_err, "R1 status clear",
        {st_cmd_ofl, st_rd_ufl, st_bus_err}, 0);

    // R4 R7: full write transfer, payload 0x13 must be sent as data
    mon_bits.delete(); mon_t.delete(); s0 = n_start; p0 = n_stop;
    slv_mode = 1;
    push(8'h01); push(8'h12); push(8'hA5); push(8'h14);
    push(8'h12);
    repeat (300) @(negedge clk);              // engine waits for payload (R4)
    push(8'h13); push(8'h14); push(8'h02);
    settle();
    exp_bits.push_back(1'b1);
    for (int i = 7; i >= 0; i--) exp_bits.push_back(8'hA5 >> i & 1);
    exp_bits.push_back(1'b1);
    for (int i = 7; i >= 0; i--) exp_bits.push_back(8'h13 >> i & 1);
    exp_bits.push_back(1'b1);
    exp_bits.push_back(1'b0);
    chk(mon_bits.size() == exp_bits.size(), "R4 bit count", mon_bits.size(), exp_bits.size());
    if (mon_bits.size() == exp_bits.size())
      for (int i = 0; i < exp_bits.size(); i++)
        chk(mon_bits[i] == exp_bits[i], "R4 payload bit", 32'(mon_bits[i]), 32'(exp_bits[i]));
    chk(!st_bus_err && !rd_ready, "R4 payload 0x13 not read", {st_bus_err, rd_ready}, 0);
    chk(n_start == s0 + 1, "R7 start seen", n_start, s0 + 1);
    chk(n_stop == p0 + 1, "R7 stop seen", n_stop, p0 + 1);
    if (mon_t.size() > 3)
      chk(mon_t[3] - mon_t[2] == F_CLK / RATE, "R2 bit period", mon_t[3] - mon_t[2], F_CLK / RATE);

    // R6 NACK, then R11 clear
    slv_mode = 0;
    push(8'h14); settle();
    chk(st_bus_err, "R6 nack error", st_bus_err, 1);
    pulse_clr(); @(negedge clk);
    chk(!st_bus_err, "R11 clear", st_bus_err, 0);

    // R10 unknown opcode
    mon_bits.delete();
    push(8'h7E); repeat (10) @(negedge clk);
    chk(st_bus_err, "R10 unknown sets error", st_bus_err, 1);
    chk(mon_bits.size() == 0 && cmd_empty, "R10 no bus activity", mon_bits.size(), 0);
    pulse_clr();

    // R3 R12 single 0 bit then hold
    push(8'h10); settle();
    chk(scl_o && !sda_o, "R12 hold after 0 bit", {scl_o, sda_o}, 2'b10);
    push(8'h11); settle();
    chk(scl_o && sda_o, "R3 one bit", {scl_o, sda_o}, 2'b11);

    // R5 read byte
    @(negedge clk); slv_byte = 8'hC3; slv_mode = 2;
    push(8'h13); push(8'h11); settle();
    chk(rd_ready && rd_data == 8'hC3, "R5 read byte", rd_data, 8'hC3);
    pulse_pop(); @(negedge clk);
    chk(!rd_ready, "R5 pop empties", rd_ready, 0);

    // R5 stall when read queue full, R9 underflow
    slv_mode = 0;
    for (int i = 0; i < 5; i++) push(8'h13);
    repeat (6 * 8 * 4 * QL) @(negedge clk);
    chk(!cmd_empty && rd_ready, "R5 read held while full", cmd_empty, 0);
    pulse_pop(); settle();
    chk(cmd_empty, "R5 held read resumes", cmd_empty, 1);
    for (int i = 0; i < 5; i++) pulse_pop();
    @(negedge clk);
    chk(st_rd_ufl && !rd_ready, "R9 underflow", st_rd_ufl, 1);

    // R8 overflow
    @(negedge clk); cmd_wr = 1; cmd_data = 8'h11;
    for (int i = 0; i < 11; i++) @(negedge clk);
    cmd_wr = 0;
    chk(st_cmd_ofl, "R8 overflow", st_cmd_ofl, 1);
    settle();
    pulse_clr(); @(negedge clk);
    chk(!st_cmd_ofl && !st_rd_ufl, "R11 clear all", {st_cmd_ofl, st_rd_ufl}, 0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule